// File: doc/BRIEF.md
# Synchronous DRAM Command Sequencer

This block sits between a simple host port and one 16-bit, four-bank synchronous DRAM. Every host request becomes a closed-page access: a row activate, then one column read or write with automatic precharge. The block emits the chip-select, row-strobe, column-strobe and write-enable pattern for each operation from registers. All minimum gaps between commands come from nanosecond parameters and a clock-period parameter, rounded up to whole cycles. The block also performs the start-up sequence, programs the mode register and inserts an auto refresh at a fixed interval.

The host side follows valid/ready rules. A request is taken on a rising edge where `host_valid` and `host_ready` are both high. Until that edge the host must hold the request and its fields stable. `host_ready` stays low through power-up, initialisation, a pending or running refresh, and the whole of each access. The read return has no back-pressure: `rd_valid` pulses for one cycle and the data must be taken in that cycle. There is only ever one access in flight, so read returns arrive in request order.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: CKE is low while reset is held and high from the first edge after it, and stays high. After reset, the command bus carries no-op (CS, RAS, CAS, WE = L,H,H,H) for at least PWRUP_CYC cycles while `host_ready` is low.
- R2: After power-up, the first four commands are, in order: a precharge with A10 high (all banks), an auto refresh, a second auto refresh, and a mode set.
- R3: The mode set drives BA = 0 and A = 12'h020 for read latency 2 or 12'h030 for read latency 3. That word means burst length 1, sequential order, burst write, and the latency code in A6..A4.
- R4: Every command uses one of these CS,RAS,CAS,WE patterns: mode set LLLL, auto refresh LLLH, precharge LLHL, activate LLHH, write LHLL, read LHLH, no-op LHHH.
- R5: Host address bits 22..21 give the bank and bits 20..9 give the row on the activate. Bits 8..0 give the column on A8..A0 of the read or write. The read or write drives A10 high (auto-precharge) and A11, A9 low.
- R6: A read or write comes at least ceil(20 ns / period) cycles after the activate to its bank. Two activates are at least ceil(63 ns / period) cycles apart.
- R7: Further minimum gaps, all in cycles. A write is followed by at least 2 + ceil(20 ns / period) before the next activate or refresh. A refresh is followed by at least ceil(63 ns / period) before any command. A precharge is followed by at least ceil(20 ns / period). A mode set is followed by at least 2.
- R8: `sd_dq_oe` is high only in a write command cycle. In that cycle `sd_dq_out` equals the request's write data and `sd_dqm` equals the inverted `host_be` (bit 1 is the upper byte). On a read command `sd_dqm` is 2'b00.
- R9: `rd_valid` is high for exactly one cycle, READ_LAT cycles after the read command cycle. `rd_data` then holds the `sd_dq_in` value present READ_LAT-1 cycles after the read command. No other cycle has `rd_valid` high.
- R10: After initialisation, consecutive auto refreshes are between REF+1 and REF+ceil(20 ns/period)+G cycles apart. Here REF = ceil(REF_INTERVAL_NS / period) and G = max(ceil(63/period) − ceil(20/period), 2 + ceil(20/period)). The interval timer restarts at each refresh.
- R11: A due refresh is issued before any further host request is accepted, even when `host_valid` is held high continuously.
- R12: An activate occurs only for an accepted request, and exactly one cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all activity on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_valid | input | 1 | Request present |
| host_ready | output | 1 | Request may be taken on this edge |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 23 | Word address {bank, row, column} |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Byte enables, bit 1 upper byte |
| rd_valid | output | 1 | Read data valid (one-cycle pulse) |
| rd_data | output | 16 | Read data |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_a | output | 12 | Row/column/mode address |
| sd_dqm | output | 2 | Byte masks, bit 1 upper byte |
| sd_dq_out | output | 16 | Data toward memory |
| sd_dq_oe | output | 1 | Drive enable for `sd_dq_out` |
| sd_dq_in | input | 16 | Data from memory |

## Verification
The assertions assume two things about the host. It keeps `host_valid` and its fields steady until acceptance. It never relies on a read return being delayed. The bench drivers change requests only on falling edges, and hold each one until the sampled `host_ready` shows it was taken. The memory side is a bench model that answers reads exactly READ_LAT-1 cycles after the read command and drives random values in every other cycle. Any capture in the wrong cycle therefore shows up as a data mismatch.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } cmd_e;

  typedef enum logic [2:0] {
    ST_PWR, ST_IREF1, ST_IREF2, ST_IMRS, ST_IDLE, ST_COL
  } seq_state_e;

  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
  parameter int unsigned PERIOD = 3900
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issued,
  output logic pending
);
  localparam int W = $clog2(PERIOD + 1);
  localparam logic [W-1:0] LOAD = W'(PERIOD - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= LOAD;
      pending <= 1'b0;
    end else if (issued) begin
      cnt     <= LOAD;
      pending <= 1'b0;
    end else if (cnt == '0) begin
      pending <= 1'b1;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  // R10: a due refresh stays due until it is issued
  a_r10_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !issued |=> pending);

endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe #(
  parameter int unsigned LAT = 3,
  parameter int unsigned DW  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [DW-1:0] dq_in,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  logic [LAT-1:0] stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      stage    <= {stage[LAT-2:0], issue};
      rd_valid <= stage[LAT-1];
      if (stage[LAT-1]) rd_data <= dq_in;
    end
  end

  // R9: at most one read in flight through the pipe
  a_r9_single_inflight: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(stage) <= 1);

endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_cmd_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS   = 4,
  parameter int unsigned TRCD_NS         = 20,
  parameter int unsigned TRP_NS          = 20,
  parameter int unsigned TRC_NS          = 63,
  parameter int unsigned TRFC_NS         = 63,
  parameter int unsigned TWR_CYC         = 2,
  parameter int unsigned TMRD_CYC        = 2,
  parameter int unsigned REF_INTERVAL_NS = 15600,
  parameter int unsigned PWRUP_CYC       = 25000,
  parameter int unsigned READ_LAT        = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_valid,
  output logic        host_ready,
  input  logic        host_we,
  input  logic [22:0] host_addr,
  input  logic [15:0] host_wdata,
  input  logic [1:0]  host_be,
  output logic        rd_valid,
  output logic [15:0] rd_data,
  output logic        sd_cke,
  output logic        sd_cs_n,
  output logic        sd_ras_n,
  output logic        sd_cas_n,
  output logic        sd_we_n,
  output logic [1:0]  sd_ba,
  output logic [11:0] sd_a,
  output logic [1:0]  sd_dqm,
  output logic [15:0] sd_dq_out,
  output logic        sd_dq_oe,
  input  logic [15:0] sd_dq_in
);
  localparam int unsigned TRCD_C = ns_to_cyc(TRCD_NS, CLK_PERIOD_NS);
  localparam int unsigned TRP_C  = ns_to_cyc(TRP_NS, CLK_PERIOD_NS);
  localparam int unsigned TRC_C  = ns_to_cyc(TRC_NS, CLK_PERIOD_NS);
  localparam int unsigned TRFC_C = ns_to_cyc(TRFC_NS, CLK_PERIOD_NS);
  localparam int unsigned REF_C  = ns_to_cyc(REF_INTERVAL_NS, CLK_PERIOD_NS);
  localparam int unsigned GAP_C  = umax(TRC_C - TRCD_C, TWR_CYC + TRP_C);
  localparam int unsigned MAXW   = umax(umax(PWRUP_CYC, TRFC_C), umax(GAP_C, TRCD_C));
  localparam int          CW     = $clog2(MAXW + 1);
  localparam logic [11:0] MODE_WORD = {5'b0, 3'(READ_LAT), 4'b0};
  localparam logic [5:0]  TRCD_6 = 6'(TRCD_C);

  seq_state_e  state, n_state;
  logic [CW-1:0] cnt, n_cnt;
  cmd_e        cmd_q, n_cmd;
  logic [1:0]  ba_q, n_ba;
  logic [11:0] a_q, n_a;
  logic [1:0]  dqm_q, n_dqm;
  logic [15:0] dout_q, n_dout;
  logic        oe_q, n_oe;
  logic        cke_q;

  logic        req_we;
  logic [1:0]  req_bank, req_be;
  logic [8:0]  req_col;
  logic [15:0] req_wdata;

  logic        ref_pend, do_ref, do_rd, accept;

  sdram_ref_timer #(.PERIOD(REF_C)) u_ref (
    .clk(clk), .rst_n(rst_n), .issued(do_ref), .pending(ref_pend)
  );

  sdram_rd_pipe #(.LAT(READ_LAT), .DW(16)) u_rd (
    .clk(clk), .rst_n(rst_n), .issue(do_rd), .dq_in(sd_dq_in),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign host_ready = (state == ST_IDLE) && (cnt == '0) && !ref_pend;

  always_comb begin
    n_state = state;
    n_cnt   = cnt;
    n_cmd   = CMD_NOP;
    n_ba    = ba_q;
    n_a     = a_q;
    n_dqm   = 2'b00;
    n_dout  = dout_q;
    n_oe    = 1'b0;
    do_ref  = 1'b0;
    do_rd   = 1'b0;
    accept  = 1'b0;
    if (cnt != '0) begin
      n_cnt = cnt - 1'b1;
    end else begin
      case (state)
        ST_PWR: begin
          n_cmd = CMD_PRE; n_ba = 2'b00; n_a = 12'h400;
          n_cnt = CW'(TRP_C - 1); n_state = ST_IREF1;
        end
        ST_IREF1: begin
          n_cmd = CMD_REF; do_ref = 1'b1;
          n_cnt = CW'(TRFC_C - 1); n_state = ST_IREF2;
        end
        ST_IREF2: begin
          n_cmd = CMD_REF; do_ref = 1'b1;
          n_cnt = CW'(TRFC_C - 1); n_state = ST_IMRS;
        end
        ST_IMRS: begin
          n_cmd = CMD_MRS; n_ba = 2'b00; n_a = MODE_WORD;
          n_cnt = CW'(TMRD_CYC - 1); n_state = ST_IDLE;
        end
        ST_IDLE: begin
          if (ref_pend) begin
            n_cmd = CMD_REF; do_ref = 1'b1;
            n_cnt = CW'(TRFC_C - 1);
          end else if (host_valid) begin
            accept = 1'b1;
            n_cmd = CMD_ACT; n_ba = host_addr[22:21]; n_a = host_addr[20:9];
            n_cnt = CW'(TRCD_C - 1); n_state = ST_COL;
          end
        end
        ST_COL: begin
          n_ba  = req_bank;
          n_a   = {3'b010, req_col};
          n_cnt = CW'(GAP_C - 1);
          n_state = ST_IDLE;
          if (req_we) begin
            n_cmd = CMD_WR; n_oe = 1'b1; n_dout = req_wdata; n_dqm = ~req_be;
          end else begin
            n_cmd = CMD_RD; do_rd = 1'b1;
          end
        end
        default: n_state = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_PWR;
      cnt    <= CW'(PWRUP_CYC - 1);
      cmd_q  <= CMD_NOP;
      ba_q   <= 2'b00;
      a_q    <= 12'h000;
      dqm_q  <= 2'b00;
      dout_q <= 16'h0000;
      oe_q   <= 1'b0;
      cke_q  <= 1'b0;
    end else begin
      state  <= n_state;
      cnt    <= n_cnt;
      cmd_q  <= n_cmd;
      ba_q   <= n_ba;
      a_q    <= n_a;
      dqm_q  <= n_dqm;
      dout_q <= n_dout;
      oe_q   <= n_oe;
      cke_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_we <= 1'b0; req_bank <= 2'b00; req_col <= 9'h0;
      req_be <= 2'b00; req_wdata <= 16'h0;
    end else if (accept) begin
      req_we    <= host_we;
      req_bank  <= host_addr[22:21];
      req_col   <= host_addr[8:0];
      req_be    <= host_be;
      req_wdata <= host_wdata;
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_cke    = cke_q;
  assign sd_ba     = ba_q;
  assign sd_a      = a_q;
  assign sd_dqm    = dqm_q;
  assign sd_dq_out = dout_q;
  assign sd_dq_oe  = oe_q;

  // cycles since the last activate, saturating
  logic [5:0] since_act;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  since_act <= 6'h3f;
    else if (cmd_q == CMD_ACT)   since_act <= 6'd1;
    else if (since_act != 6'h3f) since_act <= since_act + 6'd1;
  end

  a_r1_cke_stays: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cke |=> sd_cke);
  a_r6_col_after_act: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> since_act >= TRCD_6);
  a_r7_mrs_then_nop: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_MRS) |=> (cmd_q == CMD_NOP));
  a_r9_rd_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cmd_q == CMD_RD, READ_LAT));
  a_r11_ref_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pend && state == ST_IDLE && cnt == '0) |=> (cmd_q == CMD_REF));
  a_r12_accept_act: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_ready) |=> (cmd_q == CMD_ACT));

endmodule

// File: tb/tb_sdram_cmd_ctrl.sv
module tb_sdram_cmd_ctrl;
  localparam int PER   = 4;
  localparam int CL    = 3;
  localparam int PWR   = 64;
  localparam int B_TRCD = (20 + PER - 1) / PER;
  localparam int B_TRP  = (20 + PER - 1) / PER;
  localparam int B_TRC  = (63 + PER - 1) / PER;
  localparam int B_TRFC = (63 + PER - 1) / PER;
  localparam int B_TWR  = 2;
  localparam int B_REF  = (15600 + PER - 1) / PER;
  localparam int B_GAP  = ((B_TRC - B_TRCD) > (B_TWR + B_TRP)) ? (B_TRC - B_TRCD) : (B_TWR + B_TRP);
  localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                         C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101, C_NOP = 4'b0111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_valid = 1'b0, host_we = 1'b0;
  logic [22:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [1:0]  host_be = '0;
  logic host_ready, rd_valid;
  logic [15:0] rd_data;
  logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [1:0] sd_ba, sd_dqm;
  logic [11:0] sd_a;
  logic [15:0] sd_dq_out;
  logic [15:0] dq_in_r = '0;

  always #2 clk = ~clk;

  sdram_cmd_ctrl #(.CLK_PERIOD_NS(PER), .PWRUP_CYC(PWR), .READ_LAT(CL)) dut (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata), .host_be(host_be),
    .rd_valid(rd_valid), .rd_data(rd_data), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
    .sd_a(sd_a), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
    .sd_dq_in(dq_in_r)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] initv(input logic [22:0] k);
    return k[15:0] ^ {k[22:16], 9'h0} ^ 16'hA5C3;
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d, input logic [1:0] en);
    return {en[1] ? d[15:8] : old[15:8], en[0] ? d[7:0] : old[7:0]};
  endfunction

  // host-side model and memory-side emulation
  logic [15:0] mdl [int];
  logic [15:0] emem [int];
  logic [15:0] expq [$];
  logic [11:0] open_row [4];
  bit          drv_v [8];
  logic [15:0] drv_d [8];
  bit          exp_v [8];

  logic [22:0] cur_addr;
  logic [15:0] cur_d;
  logic [1:0]  cur_be;
  bit acc_pend = 1'b0;
  int acc_cyc = 0;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  int ncmd = 0, nref = 0;
  int t_act = -1000, t_wr = -1000, t_ref = -1000, t_pre = -1000, t_mrs = -1000;

  always @(negedge clk) begin : mon
    int s;
    logic [3:0] c;
    logic [15:0] e;
    int key;
    if (rst_n && !done) begin
      s = cyc % 8;
      if (drv_v[s]) begin dq_in_r = drv_d[s]; drv_v[s] = 1'b0; end
      else dq_in_r = 16'($urandom);
      if (exp_v[s] || rd_valid) begin
        if (!exp_v[s]) chk(1'b0, "R9 rd_valid in unexpected cycle", {31'b0, rd_valid}, 32'd0);
        else if (!rd_valid) chk(1'b0, "R9 rd_valid missing at read latency", 32'd0, 32'd1);
        else begin
          e = (expq.size() != 0) ? expq.pop_front() : 16'hxxxx;
          chk(rd_data === e, "R9 read data", {16'b0, rd_data}, {16'b0, e});
        end
        exp_v[s] = 1'b0;
      end
      c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (sd_dq_oe || c == C_WR)
        chk(sd_dq_oe && c == C_WR, "R8 data drive only in write cycle", {28'b0, c}, {28'b0, C_WR});
      if (c != C_NOP) begin
        chk(c inside {C_MRS, C_REF, C_PRE, C_ACT, C_WR, C_RD}, "R4 legal command pattern", {28'b0, c}, 32'd0);
        chk(sd_cke === 1'b1, "R1 CKE high", {31'b0, sd_cke}, 32'd1);
        chk(cyc - t_mrs >= 2, "R7 mode set gap", cyc - t_mrs, 2);
        if (ncmd == 0) chk(cyc >= PWR, "R1 power-up no-op time", cyc, PWR);
        if (ncmd < 4) begin
          case (ncmd)
            0: chk(c == C_PRE && sd_a[10], "R2 init precharge-all", {sd_a, c}, {12'h400, C_PRE});
            1, 2: chk(c == C_REF, "R2 init refresh", {28'b0, c}, {28'b0, C_REF});
            default: begin
              chk(c == C_MRS, "R2 init mode set", {28'b0, c}, {28'b0, C_MRS});
              chk(sd_a == 12'h030 && sd_ba == 2'b00, "R3 mode word", {18'b0, sd_ba, sd_a}, 32'h030);
            end
          endcase
        end
        ncmd++;
        case (c)
          C_PRE: t_pre = cyc;
          C_MRS: begin
            chk(cyc - t_ref >= B_TRFC, "R7 refresh to mode set", cyc - t_ref, B_TRFC);
            t_mrs = cyc;
          end
          C_REF: begin
            chk(cyc - t_pre >= B_TRP, "R7 precharge to refresh", cyc - t_pre, B_TRP);
            chk(cyc - t_ref >= B_TRFC, "R7 refresh to refresh", cyc - t_ref, B_TRFC);
            chk(cyc - t_wr >= B_TWR + B_TRP, "R7 write to refresh", cyc - t_wr, B_TWR + B_TRP);
            if (nref >= 2) begin
              chk(cyc - t_ref >= B_REF + 1, "R10 refresh interval lower", cyc - t_ref, B_REF + 1);
              chk(cyc - t_ref <= B_REF + B_TRCD + B_GAP, "R11 refresh interval upper", cyc - t_ref, B_REF + B_TRCD + B_GAP);
            end
            nref++;
            t_ref = cyc;
          end
          C_ACT: begin
            if (!acc_pend) chk(1'b0, "R12 activate without accepted request", 32'd1, 32'd0);
            else chk(cyc == acc_cyc + 1, "R12 activate one cycle after accept", cyc, acc_cyc + 1);
            acc_pend = 1'b0;
            chk({sd_ba, sd_a} == cur_addr[22:9], "R5 bank and row", {18'b0, sd_ba, sd_a}, {18'b0, cur_addr[22:9]});
            chk(cyc - t_act >= B_TRC, "R6 activate to activate", cyc - t_act, B_TRC);
            chk(cyc - t_wr >= B_TWR + B_TRP, "R7 write to activate", cyc - t_wr, B_TWR + B_TRP);
            chk(cyc - t_ref >= B_TRFC, "R7 refresh to activate", cyc - t_ref, B_TRFC);
            open_row[sd_ba] = sd_a;
            t_act = cyc;
          end
          C_WR, C_RD: begin
            chk(cyc - t_act >= B_TRCD, "R6 activate to column", cyc - t_act, B_TRCD);
            chk({sd_ba, sd_a[11:9], sd_a[8:0]} == {cur_addr[22:21], 3'b010, cur_addr[8:0]},
                "R5 column address with auto-precharge", {18'b0, sd_ba, sd_a}, {18'b0, cur_addr[22:21], 3'b010, cur_addr[8:0]});
            key = int'({sd_ba, open_row[sd_ba], sd_a[8:0]});
            if (c == C_WR) begin
              chk(sd_dq_out == cur_d && sd_dqm == ~cur_be, "R8 write data and masks",
                  {14'b0, sd_dqm, sd_dq_out}, {14'b0, ~cur_be, cur_d});
              emem[key] = merge(emem.exists(key) ? emem[key] : initv(23'(key)), sd_dq_out, ~sd_dqm);
              t_wr = cyc;
            end else begin
              chk(sd_dqm == 2'b00, "R8 read masks low", {30'b0, sd_dqm}, 32'd0);
              drv_v[(cyc + CL - 1) % 8] = 1'b1;
              drv_d[(cyc + CL - 1) % 8] = emem.exists(key) ? emem[key] : initv(23'(key));
              exp_v[(cyc + CL) % 8] = 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // call at a falling edge; returns at the falling edge after acceptance
  task automatic host_op(input bit we, input logic [22:0] a, input logic [15:0] d, input logic [1:0] be);
    host_valid = 1'b1; host_we = we; host_addr = a; host_wdata = d; host_be = be;
    while (!host_ready) @(negedge clk);
    cur_addr = a; cur_d = d; cur_be = be;
    acc_pend = 1'b1; acc_cyc = cyc;
    if (we) mdl[a] = merge(mdl.exists(a) ? mdl[a] : initv(a), d, be);
    else expq.push_back(mdl.exists(a) ? mdl[a] : initv(a));
    @(negedge clk);
    host_valid = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  logic [22:0] pool [8];

  initial begin
    void'($urandom(32'h5EED_2024));
    for (int i = 0; i < 8; i++) begin drv_v[i] = 1'b0; exp_v[i] = 1'b0; drv_d[i] = '0; end
    pool[0] = 23'h000000; pool[1] = 23'h7FFFFF; pool[2] = 23'h200123; pool[3] = 23'h4001FF;
    pool[4] = 23'h1FFE00; pool[5] = 23'h600000; pool[6] = 23'h0ABCDE; pool[7] = 23'h355555;
    repeat (3) @(negedge clk);
    // reset state (R1)
    chk(!host_ready && !rd_valid && !sd_dq_oe && !sd_cke, "R1 reset state",
        {28'b0, host_ready, rd_valid, sd_dq_oe, sd_cke}, 32'd0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(!host_ready && sd_cke && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP,
        "R1 power-up idle", {26'b0, host_ready, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 32'h17);
    // directed corners
    host_op(1'b1, 23'h000000, 16'h1234, 2'b11);
    host_op(1'b0, 23'h000000, 16'h0, 2'b00);
    host_op(1'b1, 23'h000000, 16'hABCD, 2'b01);
    host_op(1'b0, 23'h000000, 16'h0, 2'b00);
    host_op(1'b1, 23'h7FFFFF, 16'hBEEF, 2'b10);
    host_op(1'b0, 23'h7FFFFF, 16'h0, 2'b00);
    host_op(1'b1, 23'h4001FF, 16'hFFFF, 2'b00);
    host_op(1'b0, 23'h4001FF, 16'h0, 2'b00);
    host_op(1'b0, 23'h355555, 16'h0, 2'b00);
    // random traffic
    for (int n = 0; n < 500; n++) begin
      logic [22:0] a;
      a = ($urandom % 4 == 0) ? 23'($urandom) : pool[$urandom % 8];
      host_op(1'($urandom), a, 16'($urandom), 2'($urandom));
      repeat ($urandom % 4) @(negedge clk);
    end
    // back-to-back requests across refreshes (R11)
    while (nref < 5) host_op(1'($urandom), pool[$urandom % 8], 16'($urandom), 2'($urandom));
    repeat (40) @(negedge clk);
    chk(expq.size() == 0, "R9 all reads returned", expq.size(), 0);
    chk(nref >= 5, "R10 periodic refreshes seen", nref, 5);
    finish_run();
  end
endmodule